// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a small processor core to off-chip program and data memories over a narrow pin budget. One 8-bit pin group carries the low address byte first and the data byte afterwards. A second 8-bit group carries the high address byte for the whole access. External logic uses the falling edge of an address-latch strobe to capture the low byte. The controller drives one read strobe for code, and a separate read strobe and write strobe for data.

The core makes one access at a time through a request/acknowledge port. The port carries a 16-bit address, write data, a write flag and a code/data select. For a code fetch, the controller checks an on-chip-code enable input. When that input is high, addresses below 0x1000 are served from an on-chip ROM read port with no pin activity, and addresses from 0x1000 up go off-chip. When the input is low, every code address goes off-chip. Data accesses always go off-chip. The address a data access supplies is the current data-pointer value.

An external access runs through four phases in a fixed order: latch strobe, address hold, strobe and recovery. The length of each phase is a parameter. Read data is sampled on the last strobe cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `ale` is 0, `prog_rd_n`, `data_rd_n` and `data_wr_n` are 1, `ad_oe` is 0 and `ack` is 0.
- R2: A request is a code fetch when `req_fetch`=1. It is served on-chip only when `req_fetch`=1, `onchip_code_en`=1 and the address is below 0x1000. Every other request, including every data access, runs an external bus cycle.
- R3: An on-chip fetch drives `rom_addr` with the low 12 address bits. `ack` rises on the clock edge after the accepting edge, and `rdata` then holds `rom_rdata`. No latch pulse, strobe or bus drive occurs during the fetch.
- R4: An external cycle starts with `ale`=1 for ALE_CYC clocks. During that phase `ad_out` holds the low address byte with `ad_oe`=1, and `addr_hi` holds the high byte. The low byte stays driven for HOLD_CYC clocks after `ale` falls, and `addr_hi` stays valid to the end of the cycle.
- R5: An external code fetch pulses only `prog_rd_n`, a data read pulses only `data_rd_n`, and a data write pulses only `data_wr_n`. The pulse is low for STRB_CYC clocks, and no two of these strobes are low together.
- R6: `ad_oe` is 0 whenever a read strobe is low. `rdata` takes the value of `ad_in` sampled on the last strobe clock.
- R7: During a write, `ad_out` carries `req_wdata` with `ad_oe`=1 while `data_wr_n` is low.
- R8: `ack` of an external cycle is a one-clock pulse. It appears ALE_CYC+HOLD_CYC+STRB_CYC+RECOV_CYC edges after the accepting edge.
- R9: A request raised while an access is in progress is ignored: it produces no extra acknowledge and does not change the address, strobe or data of the current access.
- R10: Reset asserted in the middle of an external cycle returns every pin to its idle level on the next clock. The next request is then served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled only while idle |
| req_fetch | input | 1 | 1 = code fetch, 0 = data access |
| req_we | input | 1 | 1 = data write |
| req_addr | input | 16 | Access address (data pointer for data accesses) |
| req_wdata | input | 8 | Write byte |
| onchip_code_en | input | 1 | 1 = low 4 KB of code space served on chip |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read result, valid with ack |
| rom_addr | output | 12 | On-chip ROM read address |
| rom_rdata | input | 8 | On-chip ROM data for rom_addr |
| ad_out | output | 8 | Shared low-address/data byte, outgoing |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | 8 | Shared byte, incoming |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, low byte captured on its fall |
| prog_rd_n | output | 1 | Code read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench targets the code-space boundary at 0x0FFF/0x1000 with the on-chip enable both set and cleared. A wrong comparison or a wrong enable polarity would send a fetch to the wrong side and return ROM data where external data was expected, or the reverse. It checks that the bus is released while read strobes are low and that the right strobe fires for each access kind. A swapped strobe or a driven read bus would show up as wrong strobe counts or as a bus conflict. It also raises a request during a busy cycle and resets the block in the middle of a write. These catch a controller that accepts overlapping work or that leaves a strobe stuck low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_AW = 16;
  localparam int XB_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROM,
    ST_ALE,
    ST_AHOLD,
    ST_STRB,
    ST_RECOV
  } xb_state_e;

  typedef struct packed {
    logic             fetch;
    logic             we;
    logic [XB_AW-1:0] addr;
    logic [XB_DW-1:0] wdata;
  } xb_req_t;
endpackage

// File: rtl/xbus_route.sv
module xbus_route #(
  parameter int AW     = 16,
  parameter int ROM_AW = 12
) (
  input  logic          fetch,
  input  logic          onchip_en,
  input  logic [AW-1:0] addr,
  output logic          int_hit
);
  logic below_rom;
  assign below_rom = (addr[AW-1:ROM_AW] == '0);
  assign int_hit   = fetch & onchip_en & below_rom;
endmodule

// File: rtl/xbus_phase_tmr.sv
module xbus_phase_tmr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/xbus_pin_drv.sv
module xbus_pin_drv
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  xb_state_e        state_d,
  input  xb_req_t          cur,
  output logic [XB_DW-1:0] ad_out,
  output logic             ad_oe,
  output logic [XB_DW-1:0] addr_hi,
  output logic             ale,
  output logic             prog_rd_n,
  output logic             data_rd_n,
  output logic             data_wr_n
);
  localparam int LO_W = XB_DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      addr_hi   <= '0;
      ale       <= 1'b0;
      prog_rd_n <= 1'b1;
      data_rd_n <= 1'b1;
      data_wr_n <= 1'b1;
    end else begin
      ale       <= 1'b0;
      prog_rd_n <= 1'b1;
      data_rd_n <= 1'b1;
      data_wr_n <= 1'b1;
      case (state_d)
        ST_ALE: begin
          ale     <= 1'b1;
          ad_oe   <= 1'b1;
          ad_out  <= cur.addr[LO_W-1:0];
          addr_hi <= cur.addr[XB_AW-1:LO_W];
        end
        ST_AHOLD: begin
          ad_oe  <= 1'b1;
          ad_out <= cur.addr[LO_W-1:0];
        end
        ST_STRB: begin
          ad_oe <= cur.we;
          if (cur.we) ad_out <= cur.wdata;
          prog_rd_n <= ~(cur.fetch & ~cur.we);
          data_rd_n <= ~(~cur.fetch & ~cur.we);
          data_wr_n <= ~cur.we;
        end
        ST_RECOV: ad_oe <= cur.we;
        default:  ad_oe <= 1'b0;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({~prog_rd_n, ~data_rd_n, ~data_wr_n}) <= 1); // R5
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!prog_rd_n || !data_rd_n) |-> !ad_oe); // R6
  AST_ALE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe); // R4
  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !data_wr_n |-> ad_oe); // R7
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ROM_AW    = 12,
  parameter int ALE_CYC   = 2,
  parameter int HOLD_CYC  = 1,
  parameter int STRB_CYC  = 3,
  parameter int RECOV_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_fetch,
  input  logic              req_we,
  input  logic [XB_AW-1:0]  req_addr,
  input  logic [XB_DW-1:0]  req_wdata,
  input  logic              onchip_code_en,
  output logic              ack,
  output logic [XB_DW-1:0]  rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [XB_DW-1:0]  rom_rdata,
  output logic [XB_DW-1:0]  ad_out,
  output logic              ad_oe,
  input  logic [XB_DW-1:0]  ad_in,
  output logic [XB_DW-1:0]  addr_hi,
  output logic              ale,
  output logic              prog_rd_n,
  output logic              data_rd_n,
  output logic              data_wr_n
);
  localparam int MAX_AB = (ALE_CYC > HOLD_CYC) ? ALE_CYC : HOLD_CYC;
  localparam int MAX_SR = (STRB_CYC > RECOV_CYC) ? STRB_CYC : RECOV_CYC;
  localparam int MAXC   = (MAX_AB > MAX_SR) ? MAX_AB : MAX_SR;
  localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;

  xb_state_e         state_q, state_d;
  xb_req_t           cap_q, incoming, cur;
  logic              accept, int_hit, tmr_done, tmr_load;
  logic [CW-1:0]     load_val;
  logic              ack_q;
  logic [XB_DW-1:0]  rdata_q;
  logic [ROM_AW-1:0] rom_addr_q;

  assign incoming = '{fetch: req_fetch, we: req_we & ~req_fetch,
                      addr: req_addr, wdata: req_wdata};
  assign cur = accept ? incoming : cap_q;

  xbus_route #(.AW(XB_AW), .ROM_AW(ROM_AW)) route_i (
    .fetch(req_fetch), .onchip_en(onchip_code_en),
    .addr(req_addr), .int_hit(int_hit));

  xbus_phase_tmr #(.CW(CW)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load),
    .load_val(load_val), .done(tmr_done));

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin
        accept  = 1'b1;
        state_d = int_hit ? ST_ROM : ST_ALE;
      end
      ST_ROM:   state_d = ST_IDLE;
      ST_ALE:   if (tmr_done) state_d = ST_AHOLD;
      ST_AHOLD: if (tmr_done) state_d = ST_STRB;
      ST_STRB:  if (tmr_done) state_d = ST_RECOV;
      ST_RECOV: if (tmr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_ALE:   load_val = CW'(ALE_CYC - 1);
      ST_AHOLD: load_val = CW'(HOLD_CYC - 1);
      ST_STRB:  load_val = CW'(STRB_CYC - 1);
      ST_RECOV: load_val = CW'(RECOV_CYC - 1);
      default:  load_val = '0;
    endcase
  end
  assign tmr_load = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cap_q      <= '0;
      ack_q      <= 1'b0;
      rdata_q    <= '0;
      rom_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) cap_q <= incoming;
      if (accept && int_hit) rom_addr_q <= req_addr[ROM_AW-1:0];
      ack_q <= (state_q == ST_ROM) || (state_q == ST_RECOV && tmr_done);
      if (state_q == ST_ROM) rdata_q <= rom_rdata;
      else if (state_q == ST_STRB && tmr_done && !cap_q.we) rdata_q <= ad_in;
    end
  end

  xbus_pin_drv pins_i (
    .clk(clk), .rst(rst), .state_d(state_d), .cur(cur),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
    .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n));

  assign ack      = ack_q;
  assign rdata    = rdata_q;
  assign rom_addr = rom_addr_q;

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R8
  AST_ROM_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ROM) |-> (!ale && prog_rd_n && data_rd_n && data_wr_n && !ad_oe)); // R3
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(cap_q)); // R9
  AST_NO_ACK_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
    (!prog_rd_n || !data_rd_n || !data_wr_n) |-> !ack); // R8
endmodule

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;
  localparam int TA = 2, TH = 1, TS = 3, TR = 1;
  localparam int EXT_LAT = TA + TH + TS + TR;
  localparam int NV = 11;

  typedef struct packed {
    logic        fetch;
    logic        we;
    logic        en;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        ext;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    {1'b1, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'h0FFF, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'h1000, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b0, 16'h0FFF, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b1, 16'hFFFF, 8'h00, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'h0123, 8'h00, 1'b1},
    {1'b0, 1'b1, 1'b1, 16'h0456, 8'hA5, 1'b1},
    {1'b0, 1'b1, 1'b0, 16'hBEEF, 8'h5A, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'hC3C3, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b1, 16'h0ABC, 8'h00, 1'b0}
  };

  function automatic logic [7:0] rom_f(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'h9};
  endfunction
  function automatic logic [7:0] xc_f(input logic [15:0] a);
    return a[7:0] + a[15:8];
  endfunction
  function automatic logic [7:0] xd_f(input logic [15:0] a);
    return ~a[7:0] ^ a[15:8];
  endfunction

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, req_fetch = 1'b0, req_we = 1'b0, onchip_code_en = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ack, ad_oe, ale, prog_rd_n, data_rd_n, data_wr_n;
  logic [7:0] rdata, rom_rdata, ad_out, ad_in, addr_hi;
  logic [11:0] rom_addr;

  always #4 clk = ~clk;

  xbus_ctrl #(.ROM_AW(12), .ALE_CYC(TA), .HOLD_CYC(TH), .STRB_CYC(TS), .RECOV_CYC(TR)) dut_i (
    .clk(clk), .rst(rst), .req(req), .req_fetch(req_fetch), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .onchip_code_en(onchip_code_en),
    .ack(ack), .rdata(rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale),
    .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n));

  // memory models
  logic [7:0]  lat_lo = '0;
  logic [15:0] fall_addr = '0, wr_a = '0;
  logic [7:0]  wr_d = '0;
  logic ale_p = 1'b0, prog_p = 1'b1, rd_p = 1'b1, wr_p = 1'b1;
  int ale_cnt = 0, prog_cnt = 0, rd_cnt = 0, wr_cnt = 0, strb_len = 0, oe_bad = 0, ack_cnt = 0;
  logic mon_clr = 1'b0;

  assign rom_rdata = rom_f(rom_addr);
  assign ad_in = !prog_rd_n ? xc_f({addr_hi, lat_lo}) :
                 (!data_rd_n ? xd_f({addr_hi, lat_lo}) : 8'h00);

  always @(posedge clk) begin
    if (mon_clr) begin
      ale_cnt = 0; prog_cnt = 0; rd_cnt = 0; wr_cnt = 0;
      strb_len = 0; oe_bad = 0; ack_cnt = 0;
    end else begin
      if (ale && !ale_p) ale_cnt++;
      if (!prog_rd_n && prog_p) prog_cnt++;
      if (!data_rd_n && rd_p) rd_cnt++;
      if (!data_wr_n && wr_p) wr_cnt++;
      if (!prog_rd_n || !data_rd_n || !data_wr_n) strb_len++;
      if ((!prog_rd_n || !data_rd_n) && ad_oe) oe_bad++;
      if (ack) ack_cnt++;
    end
    if (ale) lat_lo <= ad_out;
    if (!ale && ale_p && ad_oe) fall_addr <= {addr_hi, ad_out};
    if (!data_wr_n) begin wr_a <= {addr_hi, lat_lo}; wr_d <= ad_out; end
    ale_p = ale; prog_p = prog_rd_n; rd_p = data_rd_n; wr_p = data_wr_n;
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input vec_t v);
    @(negedge clk);
    req_fetch = v.fetch; req_we = v.we; onchip_code_en = v.en;
    req_addr = v.addr; req_wdata = v.wdata; req = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    req = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_ack(output int lat);
    lat = 0;
    while (!ack && lat < 60) begin @(negedge clk); lat++; end
  endtask

  task automatic run_vec(input vec_t v);
    int lat;
    logic [7:0] exp_d;
    start(v);
    wait_ack(lat);
    if (!v.ext) begin
      chk("R3 rom latency", lat, 1);
      chk("R3 rom data", rdata, rom_f(v.addr[11:0]));
      chk("R3 rom addr", rom_addr, v.addr[11:0]);
      chk("R3 no latch pulse", ale_cnt, 0);
      chk("R3 no strobe", prog_cnt + rd_cnt + wr_cnt, 0);
    end else begin
      chk("R8 ext latency", lat, EXT_LAT);
      chk("R2 one latch pulse", ale_cnt, 1);
      chk("R4 latched address", fall_addr, v.addr);
      chk("R5 code strobe count", prog_cnt, (v.fetch) ? 1 : 0);
      chk("R5 data read strobe count", rd_cnt, (!v.fetch && !v.we) ? 1 : 0);
      chk("R5 write strobe count", wr_cnt, v.we ? 1 : 0);
      chk("R5 strobe length", strb_len, TS);
      chk("R6 bus released on read", oe_bad, 0);
      if (v.we) begin
        chk("R7 write address", wr_a, v.addr);
        chk("R7 write data", wr_d, v.wdata);
      end else begin
        exp_d = v.fetch ? xc_f(v.addr) : xd_f(v.addr);
        chk("R6 read data", rdata, exp_d);
      end
    end
    @(negedge clk);
    chk("R8 ack single pulse", ack, 0);
  endtask

  initial begin
    int lat;
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R1 reset ale", ale, 0);
    chk("R1 reset strobes", {prog_rd_n, data_rd_n, data_wr_n}, 3'b111);
    chk("R1 reset oe", ad_oe, 0);
    chk("R1 reset ack", ack, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {ale, ad_oe, ack, prog_rd_n, data_rd_n, data_wr_n}, 6'b000111);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: request during a busy cycle is ignored
    v = {1'b0, 1'b0, 1'b1, 16'h2222, 8'h00, 1'b1};
    start(v);
    @(negedge clk); @(negedge clk);
    req_fetch = 1'b1; req_addr = 16'h3333; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_ack(lat);
    chk("R9 busy read data", rdata, xd_f(16'h2222));
    chk("R9 busy address", fall_addr, 16'h2222);
    chk("R9 no code strobe", prog_cnt, 0);
    repeat (12) @(negedge clk);
    chk("R9 single ack", ack_cnt, 1);
    chk("R9 single latch pulse", ale_cnt, 1);

    // R10: reset in the middle of a write
    v = {1'b0, 1'b1, 1'b1, 16'h4444, 8'h3C, 1'b1};
    start(v);
    repeat (3) @(negedge clk);
    chk("R10 write strobe active before reset", data_wr_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 pins idle after reset", {ale, ad_oe, ack, prog_rd_n, data_rd_n, data_wr_n}, 6'b000111);
    rst = 1'b0;
    run_vec({1'b1, 1'b0, 1'b1, 16'h0555, 8'h00, 1'b0});
    run_vec({1'b0, 1'b0, 1'b1, 16'h7E01, 8'h00, 1'b1});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
    $finish;
  end
endmodule